// File: doc/BRIEF.md
# XDS Packet Class Filter

This block sits behind a line-21 data slicer and watches the byte pairs it recovers. Each pair is classified by its leading byte as a packet start, a packet continuation, a packet end, a data pair, a caption control pair or padding. A small context tracker remembers which extended data service packet class is open, and the type byte last seen for each class. A pair is passed only when its class is enabled in a host-written class mask and, if a secondary type code is set, the packet's type byte equals it. Pairs from odd fields are never considered. A mask of zero, the reset value, switches recovery off.

A passing pair is written at once into a two-byte holding register. Two flags show the host that data waits: a data-available flag and a two-bytes-ready flag. The host reads the held bytes directly, with no select step first. Reading the first byte clears only the two-bytes flag. Reading the second byte clears both flags and the overrun flag. If a new pair arrives while data still waits, the new pair replaces it and the overrun flag is raised.

Top module: `xds_class_filter`

## Requirements
- R1: After reset, out_b0, out_b1, dav, rd2 and overrun are all zero.
- R2: While class_mask is 00h, no pair is loaded and the held bytes and flags are left as they were.
- R3: A pair presented with even_field low is ignored: it is not loaded and does not change the packet context.
- R4: A leading byte whose low 7 bits (bit 7 is parity and is ignored) are an odd value from 01h to 0Dh opens a packet of class (code-1)>>1. The second byte is that class's type. The pair is loaded when class_mask bit [class] is 1 and the secondary check of R7 holds.
- R5: A leading byte whose low 7 bits are an even value from 02h to 0Eh resumes class (code-1)>>1. It uses the type stored by that class's last start, and it is loaded under the same mask and secondary conditions as R4.
- R6: A pair whose leading low 7 bits are 20h or above is data, and 0Fh marks the end of a packet. Either is loaded only while a packet is open and that packet's class and type still pass. An end pair then closes the packet.
- R7: When the low 7 bits of sec_code are nonzero, a packet passes only if its type byte's low 7 bits equal them. When they are zero, the type is not checked.
- R8: A leading low-7-bit value of 10h to 1Fh (caption control) closes any open packet and is not loaded. A value of 00h is not loaded and leaves the context unchanged.
- R9: A passing pair appears on out_b0/out_b1 exactly as received one clock later, with dav and rd2 both high.
- R10: A host read with host_sel=0 clears rd2 only. A read with host_sel=1 clears dav, rd2 and overrun. rd2 is never high while dav is low.
- R11: Loading a pair while dav is high, without a simultaneous second-byte read, replaces the held bytes and sets overrun.
- R12: When a load and a host read fall in the same cycle, the load wins: dav and rd2 end high and the new bytes are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pair_vld | input | 1 | One-cycle strobe: a recovered byte pair is present |
| pair_b0 | input | 8 | First (leading) byte of the pair |
| pair_b1 | input | 8 | Second byte of the pair |
| even_field | input | 1 | High when the pair came from the even field |
| class_mask | input | 8 | Class enable bits; bit i enables class i; 00h disables recovery |
| sec_code | input | 8 | Secondary type code; zero in the low 7 bits means no type check |
| host_rd | input | 1 | One-cycle host read strobe of a held byte |
| host_sel | input | 1 | Which byte the host reads: 0 first, 1 second |
| out_b0 | output | 8 | Held first byte |
| out_b1 | output | 8 | Held second byte |
| dav | output | 1 | Data available |
| rd2 | output | 1 | Two bytes remain to be read |
| overrun | output | 1 | A held pair was overwritten before being read |

## Verification
Assertions check on every cycle that rd2 never stands without dav, that the held bytes stay still unless a load occurs, and that odd-field pairs and an all-zero mask cause no load. They also check that a caption code leaves no packet open, that a second-byte read clears the flags, and that a load over waiting data sets the overrun flag. Whether the right pairs pass depends on context built over many pairs: the class stored for continuations, the type kept from the last start, and the secondary match. Only the bench's scenarios can show this, by comparing every cycle against a separately written packet model under random and directed pair streams.

// File: rtl/xds_filt_pkg.sv
package xds_filt_pkg;
   // classification of a recovered pair by its leading byte
   typedef enum logic [2:0] {
      PK_NONE  = 3'd0,
      PK_START = 3'd1,
      PK_CONT  = 3'd2,
      PK_END   = 3'd3,
      PK_DATA  = 3'd4,
      PK_CAPT  = 3'd5
   } pair_kind_e;

   localparam int unsigned LEAD_W  = 8;
   localparam int unsigned CLS_W   = 3;
   localparam int unsigned MAX_CLS = 7;
endpackage

// File: rtl/xds_code_decode.sv
module xds_code_decode
   import xds_filt_pkg::*;
#(
   parameter bit STRIP_PARITY = 1'b1
) (
   input  logic [LEAD_W-1:0] lead_i,
   output pair_kind_e        kind_o,
   output logic [CLS_W-1:0]  cls_o
);
   logic [LEAD_W-1:0] code;
   logic [3:0]        code_m1;

   generate
      if (STRIP_PARITY) begin : g_strip
         assign code = {1'b0, lead_i[LEAD_W-2:0]};
      end else begin : g_full
         assign code = lead_i;
      end
   endgenerate

   assign code_m1 = code[3:0] - 4'd1;
   assign cls_o   = code_m1[3:1];

   always_comb begin
      if (code == '0)
         kind_o = PK_NONE;
      else if (code < 8'h0F)
         kind_o = code[0] ? PK_START : PK_CONT;
      else if (code == 8'h0F)
         kind_o = PK_END;
      else if (code < 8'h20)
         kind_o = PK_CAPT;
      else
         kind_o = PK_DATA;
   end
endmodule

// File: rtl/xds_ctx_track.sv
module xds_ctx_track
   import xds_filt_pkg::*;
#(
   parameter int unsigned CLASS_N      = 7,
   parameter bit          STRIP_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  pair_kind_e        kind_i,
   input  logic [CLS_W-1:0]  cls_i,
   input  logic [LEAD_W-1:0] type_i,
   input  logic [LEAD_W-1:0] mask_i,
   input  logic [LEAD_W-1:0] sec_i,
   output logic              pass_o
);
   localparam logic [LEAD_W-1:0] KMASK = STRIP_PARITY ? 8'h7F : 8'hFF;

   logic                open_q;
   logic [CLS_W-1:0]    cur_q;
   logic [LEAD_W-1:0]   type_mem [CLASS_N];
   logic [LEAD_W-1:0]   type_k, sec_k, cls_type, cur_type;
   logic                cls_ok, cur_ok, pass_c;

   assign type_k = type_i & KMASK;
   assign sec_k  = sec_i & KMASK;

   function automatic logic sec_ok(input logic [LEAD_W-1:0] t);
      return (sec_k == '0) || (sec_k == t);
   endfunction

   always_comb begin
      cls_type = '0;
      cur_type = '0;
      for (int i = 0; i < int'(CLASS_N); i++) begin
         if (cls_i == CLS_W'(i)) cls_type = type_mem[i];
         if (cur_q == CLS_W'(i)) cur_type = type_mem[i];
      end
   end

   assign cls_ok = (int'(cls_i) < int'(CLASS_N)) && mask_i[cls_i];
   assign cur_ok = (int'(cur_q) < int'(CLASS_N)) && mask_i[cur_q];

   always_comb begin
      unique case (kind_i)
         PK_START: pass_c = cls_ok && sec_ok(type_k);
         PK_CONT:  pass_c = cls_ok && sec_ok(cls_type);
         PK_END,
         PK_DATA:  pass_c = open_q && cur_ok && sec_ok(cur_type);
         default:  pass_c = 1'b0;
      endcase
   end

   assign pass_o = step_i && pass_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cur_q  <= '0;
      end else if (step_i) begin
         unique case (kind_i)
            PK_START,
            PK_CONT: begin
               open_q <= 1'b1;
               cur_q  <= cls_i;
            end
            PK_END,
            PK_CAPT: open_q <= 1'b0;
            default: ;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < int'(CLASS_N); g++) begin : g_type
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               type_mem[g] <= '0;
            else if (step_i && kind_i == PK_START && cls_i == CLS_W'(g))
               type_mem[g] <= type_k;
         end
      end
   endgenerate

   // R8
   caption_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && kind_i == PK_CAPT) |=> !open_q);

   // R6
   closed_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_q && (kind_i == PK_DATA || kind_i == PK_END)) |-> !pass_o);
endmodule

// File: rtl/xds_out_hold.sv
module xds_out_hold
   import xds_filt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_i,
   input  logic [LEAD_W-1:0] b0_i,
   input  logic [LEAD_W-1:0] b1_i,
   input  logic              rd_i,
   input  logic              rd_sel_i,
   output logic [LEAD_W-1:0] b0_o,
   output logic [LEAD_W-1:0] b1_o,
   output logic              dav_o,
   output logic              rd2_o,
   output logic              ovr_o
);
   logic rd_last;
   assign rd_last = rd_i && rd_sel_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b0_o  <= '0;
         b1_o  <= '0;
         dav_o <= 1'b0;
         rd2_o <= 1'b0;
         ovr_o <= 1'b0;
      end else if (ld_i) begin
         b0_o  <= b0_i;
         b1_o  <= b1_i;
         dav_o <= 1'b1;
         rd2_o <= 1'b1;
         ovr_o <= dav_o && !rd_last;
      end else if (rd_i) begin
         rd2_o <= 1'b0;
         if (rd_sel_i) begin
            dav_o <= 1'b0;
            ovr_o <= 1'b0;
         end
      end
   end

   // R10
   rd2_needs_dav_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd2_o |-> dav_o);

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_i |=> ($stable(b0_o) && $stable(b1_o)));

   // R11
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i && dav_o && !rd_last) |=> ovr_o);

   // R10
   second_read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_last && !ld_i) |=> (!dav_o && !rd2_o && !ovr_o));

   // R12
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (dav_o && rd2_o));
endmodule

// File: rtl/xds_class_filter.sv
module xds_class_filter
   import xds_filt_pkg::*;
#(
   parameter int unsigned CLASS_N      = 7,
   parameter bit          STRIP_PARITY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pair_vld,
   input  logic [7:0] pair_b0,
   input  logic [7:0] pair_b1,
   input  logic       even_field,
   input  logic [7:0] class_mask,
   input  logic [7:0] sec_code,
   input  logic       host_rd,
   input  logic       host_sel,
   output logic [7:0] out_b0,
   output logic [7:0] out_b1,
   output logic       dav,
   output logic       rd2,
   output logic       overrun
);
   generate
      if (CLASS_N < 1 || CLASS_N > MAX_CLS) begin : g_bad_cls
         $error("CLASS_N must lie in 1..7");
      end
   endgenerate

   pair_kind_e       kind;
   logic [CLS_W-1:0] cls;
   logic             step, pass, enabled;

   assign enabled = (class_mask != '0);
   assign step    = pair_vld && even_field;

   xds_code_decode #(.STRIP_PARITY(STRIP_PARITY)) dec_i (
      .lead_i (pair_b0),
      .kind_o (kind),
      .cls_o  (cls)
   );

   xds_ctx_track #(.CLASS_N(CLASS_N), .STRIP_PARITY(STRIP_PARITY)) ctx_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .kind_i (kind),
      .cls_i  (cls),
      .type_i (pair_b1),
      .mask_i (class_mask),
      .sec_i  (sec_code),
      .pass_o (pass)
   );

   xds_out_hold hold_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_i     (pass && enabled),
      .b0_i     (pair_b0),
      .b1_i     (pair_b1),
      .rd_i     (host_rd),
      .rd_sel_i (host_sel),
      .b0_o     (out_b0),
      .b1_o     (out_b1),
      .dav_o    (dav),
      .rd2_o    (rd2),
      .ovr_o    (overrun)
   );

   // R3
   odd_field_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !even_field |=> ($stable(out_b0) && $stable(out_b1) && !$rose(dav)));

   // R2
   mask_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (class_mask == 8'h00) |=> ($stable(out_b0) && $stable(out_b1) && !$rose(dav)));
endmodule

// File: tb/xds_class_filter_tb.sv
module xds_class_filter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pair_vld = 1'b0;
   logic [7:0] pair_b0 = '0, pair_b1 = '0;
   logic       even_field = 1'b0;
   logic [7:0] class_mask = '0, sec_code = '0;
   logic       host_rd = 1'b0, host_sel = 1'b0;
   logic [7:0] out_b0, out_b1;
   logic       dav, rd2, overrun;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model state
   bit       m_open;
   int       m_cur;
   bit [6:0] m_type [7];
   bit [7:0] m_b0, m_b1;
   bit       m_dav, m_rd2, m_ovr;

   always #4 clk = ~clk;

   xds_class_filter dut_i (
      .clk(clk), .rst_n(rst_n), .pair_vld(pair_vld), .pair_b0(pair_b0),
      .pair_b1(pair_b1), .even_field(even_field), .class_mask(class_mask),
      .sec_code(sec_code), .host_rd(host_rd), .host_sel(host_sel),
      .out_b0(out_b0), .out_b1(out_b1), .dav(dav), .rd2(rd2), .overrun(overrun)
   );

   function automatic bit type_ok(bit [6:0] t, bit [7:0] sc);
      return (sc[6:0] == 7'd0) || (sc[6:0] == t);
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      bit [6:0] code;
      bit       p;
      int       c;
      bit [6:0] t;
      code = pair_b0[6:0];
      p = 1'b0;
      if (pair_vld && even_field && code != 7'd0) begin
         if (code <= 7'd14) begin
            c = (int'(code) - 1) >> 1;
            t = code[0] ? pair_b1[6:0] : m_type[c];
            p = class_mask[c] && type_ok(t, sec_code);
            if (code[0]) m_type[c] = pair_b1[6:0];
            m_open = 1'b1;
            m_cur = c;
         end else if (code == 7'h0F) begin
            p = m_open && class_mask[m_cur] && type_ok(m_type[m_cur], sec_code);
            m_open = 1'b0;
         end else if (code < 7'h20) begin
            m_open = 1'b0;
         end else begin
            p = m_open && class_mask[m_cur] && type_ok(m_type[m_cur], sec_code);
         end
      end
      if (p) begin
         m_ovr = m_dav && !(host_rd && host_sel);
         m_b0 = pair_b0;
         m_b1 = pair_b1;
         m_dav = 1'b1;
         m_rd2 = 1'b1;
      end else if (host_rd) begin
         m_rd2 = 1'b0;
         if (host_sel) begin
            m_dav = 1'b0;
            m_ovr = 1'b0;
         end
      end
   endtask

   task automatic compare(string tag);
      check(tag, "out_b0", out_b0, m_b0);
      check(tag, "out_b1", out_b1, m_b1);
      check(tag, "dav", dav, m_dav);
      check(tag, "rd2", rd2, m_rd2);
      check(tag, "overrun", overrun, m_ovr);
   endtask

   task automatic cyc(string tag, bit v, bit [7:0] a, bit [7:0] b, bit ev,
                      bit rd, bit sel);
      @(negedge clk);
      pair_vld = v; pair_b0 = a; pair_b1 = b; even_field = ev;
      host_rd = rd; host_sel = sel;
      @(posedge clk);
      model_step();
      #1;
      compare(tag);
      @(negedge clk);
      pair_vld = 1'b0; host_rd = 1'b0;
   endtask

   task automatic pair(string tag, bit [7:0] a, bit [7:0] b);
      cyc(tag, 1'b1, a, b, 1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      #(8 * 150000);
      $display("FAIL watchdog expired");
      failures++;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int seed;
      bit [7:0] a, b;
      int k;
      seed = 32'h5EED_0123;
      void'($urandom(seed));
      m_open = 0; m_cur = 0; m_b0 = 0; m_b1 = 0;
      m_dav = 0; m_rd2 = 0; m_ovr = 0;
      for (int i = 0; i < 7; i++) m_type[i] = '0;

      repeat (3) @(posedge clk);
      #1;
      compare("R1");
      @(negedge clk) rst_n = 1'b1;

      // R2: mask zero, start and data pairs are not loaded
      pair("R2", 8'h01, 8'h03);
      pair("R2", 8'h41, 8'h22);
      class_mask = 8'h01;
      // R3: odd-field start and data ignored
      cyc("R3", 1'b1, 8'h03, 8'h05, 1'b0, 1'b0, 1'b0);
      // R4: start class 0, type 3, then data
      pair("R4", 8'h01, 8'h03);
      pair("R6", 8'h45, 8'h46);
      cyc("R10", 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0);
      cyc("R10", 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
      // R4: parity bit set on the start code, class 1 disabled
      pair("R4", 8'h83, 8'h01);
      pair("R6", 8'h50, 8'h51);
      // R5: continue class 0 resumes type 3
      pair("R5", 8'h02, 8'h30);
      pair("R11", 8'h60, 8'h61);
      // R7: secondary mismatch then match
      sec_code = 8'h04;
      pair("R7", 8'h01, 8'h03);
      pair("R7", 8'h01, 8'h04);
      // R12: load and second-byte read together
      cyc("R12", 1'b1, 8'h55, 8'h56, 1'b1, 1'b1, 1'b1);
      // R8: caption code closes packet; 00h keeps it
      pair("R8", 8'h00, 8'h00);
      pair("R8", 8'h57, 8'h58);
      pair("R8", 8'h14, 8'h2C);
      pair("R8", 8'h59, 8'h5A);
      // R6: end pair of reopened packet then closed
      pair("R6", 8'h02, 8'h00);
      pair("R6", 8'h0F, 8'h77);
      pair("R6", 8'h5B, 8'h5C);
      // R9: hold check after reads
      cyc("R9", 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
      sec_code = 8'h00;

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 63) == 0) class_mask = 8'($urandom_range(0, 255));
         if ($urandom_range(0, 63) == 0)
            sec_code = ($urandom_range(0, 1) != 0) ? 8'h00 : 8'($urandom_range(1, 4));
         k = $urandom_range(0, 9);
         if (k < 3) a = 8'($urandom_range(1, 14));
         else if (k == 3) a = 8'h0F;
         else if (k == 4) a = 8'($urandom_range(16, 31));
         else if (k == 5) a = 8'h00;
         else a = 8'($urandom_range(32, 127));
         if ($urandom_range(0, 3) == 0) a[7] = 1'b1;
         b = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(1, 4)) : 8'($urandom_range(0, 255));
         cyc("R9", $urandom_range(0, 3) != 0, a, b, $urandom_range(0, 4) != 0,
             $urandom_range(0, 2) == 0, $urandom_range(0, 1) != 0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule